// File: doc/BRIEF.md
# PCI Host Bridge Address Translator

This block sits between a simple CPU-side memory-mapped bus and a downstream PCI-style request port. Each CPU access is decoded against three address windows, and each window answers at two physical aliases. The control window holds a local 64-word configuration space, a configuration-address register, a memory base register and an I/O base register. It also has a data port. Any access to the data port becomes a 4-byte configuration transaction aimed at the address held in the configuration-address register. The memory and I/O windows add their base register to the offset within the window, wrapping modulo 2^32, and forward byte, halfword or word accesses downstream.

One state machine sequences every access. From `ST_IDLE`, a request goes to one of two places. A local or unmatched access goes straight to `ST_DONE`. An access that must go downstream goes to `ST_ISSUE`, where `dn_valid` is held until `dn_ready` and the machine then moves to `ST_WAIT`. In `ST_WAIT`, `rsp_ready` is held until `rsp_valid` and the machine then moves to `ST_DONE`. `ST_DONE` pulses `cpu_ack` for one cycle and always returns to `ST_IDLE`. The CPU holds `cpu_req` until it sees the acknowledge.

Top module: `pcib_xlate`

## Requirements
- R1: After reset, `cpu_ack` and `dn_valid` are low. Config word 0 reads `{DEVICE_ID, VENDOR_ID}` (vendor in bits 15:0, default device 0x350E). Word 1 reads 0x02900080, all other config words read 0, and the configuration-address register reads 0.
- R2: A word written at control offset 4*i, for i from 0 to 63, is returned by later reads of that offset.
- R3: Offset 0x1C0 (configuration address) reads back its last written value. Offsets 0x1C4 (memory base) and 0x1C8 (I/O base) take writes but read as 0. Other unused offsets inside the window read as 0, and writes to them change nothing.
- R4: Any access at control offset 0x220 sends one downstream request. Its kind is 0 (config), its size is 2 (word), its address is the configuration-address register, and it carries the CPU write flag and data. A read returns `rsp_data`.
- R5: A memory-window access sends one request of kind 1. Its address is the window offset plus the memory base, modulo 2^32, and `cpu_size` is passed through unchanged (0 byte, 1 half, 2 word).
- R6: An I/O-window access sends one request of kind 2. Its address is the window offset plus the I/O base, modulo 2^32, and the size is passed through unchanged.
- R7: The control window at 0x1E200000/0xFE200000 (0x224 bytes), the memory window at 0x1D000000/0xFD000000 (16 MiB) and the I/O window at 0x1E240000/0xFE240000 (256 KiB) behave the same at either alias.
- R8: Some accesses are misses: an address outside all six ranges, size code 3, or a control-window access whose size is not word. A miss sends no request, reads as 0, changes no state, and is acknowledged.
- R9: `dn_valid` and the request payload stay stable until `dn_ready`. Exactly one request is made per access, and `cpu_ack` follows the cycle after `rsp_valid` is accepted.
- R10: A local or missed access is acknowledged on the clock edge after the one that accepts it. `cpu_ack` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write |
| cpu_addr | input | 32 | CPU physical address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Access complete (one-cycle pulse) |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_kind | output | 2 | 0 config, 1 memory, 2 I/O |
| dn_addr | output | 32 | Translated address or port number |
| dn_size | output | 2 | Access size code |
| dn_write | output | 1 | Request is a write |
| dn_wdata | output | 32 | Request write data |
| rsp_valid | input | 1 | Downstream response valid |
| rsp_ready | output | 1 | Bridge waiting for a response |
| rsp_data | input | 32 | Response read data |

## Verification
Two functions can meet in adjacent accept edges. One is an update of a translation or configuration-address register. The other is the request that uses that register, which is formed in the first cycle after the update's acknowledge. The bench writes a base or address register and then issues a window or data-port access with no idle gap. The new register value must already appear in `dn_addr`. The downstream model also varies `dn_ready` and `rsp_valid` latency at random. With zero delays, acceptance and response arrive in back-to-back cycles, and the model checks that the payload is held and that only one request is made.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_REG  = 2'd1,
        WIN_MEM  = 2'd2,
        WIN_IO   = 2'd3
    } win_e;

    localparam logic [1:0] KIND_CFG = 2'd0;
    localparam logic [1:0] KIND_MEM = 2'd1;
    localparam logic [1:0] KIND_IO  = 2'd2;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int          IDXW       = 8;
    localparam logic [9:0]  OFF_CADDR  = 10'h1C0;
    localparam logic [9:0]  OFF_MBASE  = 10'h1C4;
    localparam logic [9:0]  OFF_IOBASE = 10'h1C8;
    localparam logic [9:0]  OFF_DPORT  = 10'h220;
    localparam logic [IDXW-1:0] IDX_CADDR  = IDXW'(OFF_CADDR >> 2);
    localparam logic [IDXW-1:0] IDX_MBASE  = IDXW'(OFF_MBASE >> 2);
    localparam logic [IDXW-1:0] IDX_IOBASE = IDXW'(OFF_IOBASE >> 2);
    localparam logic [IDXW-1:0] IDX_DPORT  = IDXW'(OFF_DPORT >> 2);

endpackage

// File: rtl/pcib_decode.sv
module pcib_decode
    import pcib_pkg::*;
#(
    parameter int                        ALIASES   = 2,
    parameter logic [ALIASES-1:0][31:0]  REG_BASES = {32'hFE20_0000, 32'h1E20_0000},
    parameter logic [ALIASES-1:0][31:0]  MEM_BASES = {32'hFD00_0000, 32'h1D00_0000},
    parameter logic [ALIASES-1:0][31:0]  IO_BASES  = {32'hFE24_0000, 32'h1E24_0000},
    parameter logic [31:0]               REG_SPAN  = 32'h0000_0224,
    parameter logic [31:0]               MEM_SPAN  = 32'h0100_0000,
    parameter logic [31:0]               IO_SPAN   = 32'h0004_0000
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    output win_e        win,
    output logic [31:0] offset
);

    logic [31:0] off_reg [ALIASES];
    logic [31:0] off_mem [ALIASES];
    logic [31:0] off_io  [ALIASES];
    logic        hit_reg [ALIASES];
    logic        hit_mem [ALIASES];
    logic        hit_io  [ALIASES];

    for (genvar a = 0; a < ALIASES; a++) begin : g_alias
        assign off_reg[a] = addr - REG_BASES[a];
        assign off_mem[a] = addr - MEM_BASES[a];
        assign off_io[a]  = addr - IO_BASES[a];
        assign hit_reg[a] = (addr >= REG_BASES[a]) && (off_reg[a] < REG_SPAN);
        assign hit_mem[a] = (addr >= MEM_BASES[a]) && (off_mem[a] < MEM_SPAN);
        assign hit_io[a]  = (addr >= IO_BASES[a])  && (off_io[a]  < IO_SPAN);
    end

    always_comb begin
        win    = WIN_NONE;
        offset = '0;
        for (int a = 0; a < ALIASES; a++) begin
            if (hit_mem[a]) begin win = WIN_MEM; offset = off_mem[a]; end
        end
        for (int a = 0; a < ALIASES; a++) begin
            if (hit_io[a])  begin win = WIN_IO;  offset = off_io[a];  end
        end
        for (int a = 0; a < ALIASES; a++) begin
            if (hit_reg[a]) begin win = WIN_REG; offset = off_reg[a]; end
        end
        if (size == 2'd3 || (win == WIN_REG && size != SZ_WORD)) begin
            win    = WIN_NONE;
            offset = '0;
        end
    end

endmodule

// File: rtl/pcib_regfile.sv
module pcib_regfile
    import pcib_pkg::*;
#(
    parameter int          CFG_WORDS = 64,
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h350E
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] idx,
    input  logic [31:0]     wdata,
    output logic [31:0]     rd_data,
    output logic [31:0]     cfg_addr,
    output logic [31:0]     mem_base,
    output logic [31:0]     io_base
);

    localparam int CFG_AW = $clog2(CFG_WORDS);

    logic [31:0] cfg_q [CFG_WORDS];

    function automatic logic [31:0] init_word(input int i);
        case (i)
            0:       return {DEVICE_ID, VENDOR_ID};
            1:       return 32'h0290_0080;
            default: return 32'h0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_WORDS; i++) cfg_q[i] <= init_word(i);
            cfg_addr <= '0;
            mem_base <= '0;
            io_base  <= '0;
        end else if (wr_en) begin
            if (idx < IDXW'(CFG_WORDS))   cfg_q[idx[CFG_AW-1:0]] <= wdata;
            else if (idx == IDX_CADDR)    cfg_addr <= wdata;
            else if (idx == IDX_MBASE)    mem_base <= wdata;
            else if (idx == IDX_IOBASE)   io_base  <= wdata;
        end
    end

    always_comb begin
        if (idx < IDXW'(CFG_WORDS))  rd_data = cfg_q[idx[CFG_AW-1:0]];
        else if (idx == IDX_CADDR)   rd_data = cfg_addr;
        else                         rd_data = '0;
    end

    AST_CADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_CADDR) |=> (cfg_addr == $past(wdata))); // R3

endmodule

// File: rtl/pcib_xlate.sv
module pcib_xlate
    import pcib_pkg::*;
#(
    parameter int                        CFG_WORDS = 64,
    parameter logic [15:0]               VENDOR_ID = 16'h1A2B,
    parameter logic [15:0]               DEVICE_ID = 16'h350E,
    parameter int                        ALIASES   = 2,
    parameter logic [ALIASES-1:0][31:0]  REG_BASES = {32'hFE20_0000, 32'h1E20_0000},
    parameter logic [ALIASES-1:0][31:0]  MEM_BASES = {32'hFD00_0000, 32'h1D00_0000},
    parameter logic [ALIASES-1:0][31:0]  IO_BASES  = {32'hFE24_0000, 32'h1E24_0000}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ack,
    output logic [31:0] cpu_rdata,
    output logic        dn_valid,
    input  logic        dn_ready,
    output logic [1:0]  dn_kind,
    output logic [31:0] dn_addr,
    output logic [1:0]  dn_size,
    output logic        dn_write,
    output logic [31:0] dn_wdata,
    input  logic        rsp_valid,
    output logic        rsp_ready,
    input  logic [31:0] rsp_data
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    state_e state, state_nx;

    win_e            win;
    logic [31:0]     off;
    logic [IDXW-1:0] reg_idx;
    logic            is_dport, accept, go_down, rf_wr;
    logic [31:0]     rf_rdata, cfg_addr, mem_base, io_base;

    logic [1:0]  kind_q, size_q;
    logic [31:0] addr_q, wdata_q, rdata_q;
    logic        write_q;

    pcib_decode #(
        .ALIASES  (ALIASES),
        .REG_BASES(REG_BASES),
        .MEM_BASES(MEM_BASES),
        .IO_BASES (IO_BASES)
    ) u_dec (
        .addr  (cpu_addr),
        .size  (cpu_size),
        .win   (win),
        .offset(off)
    );

    assign reg_idx  = off[IDXW+1:2];
    assign is_dport = (win == WIN_REG) && (reg_idx == IDX_DPORT);
    assign accept   = (state == ST_IDLE) && cpu_req;
    assign go_down  = (win == WIN_MEM) || (win == WIN_IO) || is_dport;
    assign rf_wr    = accept && cpu_we && (win == WIN_REG) && !is_dport;

    pcib_regfile #(
        .CFG_WORDS(CFG_WORDS),
        .VENDOR_ID(VENDOR_ID),
        .DEVICE_ID(DEVICE_ID)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_wr),
        .idx     (reg_idx),
        .wdata   (cpu_wdata),
        .rd_data (rf_rdata),
        .cfg_addr(cfg_addr),
        .mem_base(mem_base),
        .io_base (io_base)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cpu_req)   state_nx = go_down ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (dn_ready)  state_nx = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_nx = ST_DONE;
            ST_DONE:                 state_nx = ST_IDLE;
        endcase
    end

    // Request payload and read data, captured once per access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= KIND_CFG;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            kind_q  <= (win == WIN_MEM) ? KIND_MEM : (win == WIN_IO) ? KIND_IO : KIND_CFG;
            addr_q  <= (win == WIN_MEM) ? off + mem_base :
                       (win == WIN_IO)  ? off + io_base  : cfg_addr;
            size_q  <= is_dport ? SZ_WORD : cpu_size;
            write_q <= cpu_we;
            wdata_q <= cpu_wdata;
            rdata_q <= (win == WIN_REG && !cpu_we && !is_dport) ? rf_rdata : '0;
        end else if (state == ST_WAIT && rsp_valid) begin
            rdata_q <= write_q ? '0 : rsp_data;
        end
    end

    // Outputs
    always_comb begin
        cpu_ack   = (state == ST_DONE);
        dn_valid  = (state == ST_ISSUE);
        rsp_ready = (state == ST_WAIT);
        cpu_rdata = rdata_q;
        dn_kind   = kind_q;
        dn_addr   = addr_q;
        dn_size   = size_q;
        dn_write  = write_q;
        dn_wdata  = wdata_q;
    end

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable({dn_kind, dn_addr, dn_size, dn_write, dn_wdata}))); // R9
    AST_RSP_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && rsp_valid) |=> cpu_ack); // R9
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack); // R10
    AST_MISS_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win == WIN_NONE) |=> (cpu_ack && cpu_rdata == 32'h0 && !dn_valid)); // R8
    AST_CFG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_kind == KIND_CFG) |-> (dn_size == SZ_WORD)); // R4

endmodule

// File: tb/sim_pcib_xlate.sv
module sim_pcib_xlate;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] VEND       = 16'h1A2B;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata;
    logic [1:0]  cpu_size;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        dn_valid, dn_ready, dn_write, rsp_valid, rsp_ready;
    logic [1:0]  dn_kind, dn_size;
    logic [31:0] dn_addr, dn_wdata, rsp_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcib_xlate #(.VENDOR_ID(VEND)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_addr(dn_addr),
        .dn_size(dn_size), .dn_write(dn_write), .dn_wdata(dn_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rsp_fn(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] reg_base(input int a);
        return (a != 0) ? 32'hFE20_0000 : 32'h1E20_0000;
    endfunction
    function automatic logic [31:0] mem_base_a(input int a);
        return (a != 0) ? 32'hFD00_0000 : 32'h1D00_0000;
    endfunction
    function automatic logic [31:0] io_base_a(input int a);
        return (a != 0) ? 32'hFE24_0000 : 32'h1E24_0000;
    endfunction

    // Downstream target model
    int          nreq = 0;
    logic [1:0]  l_kind, l_size;
    logic [31:0] l_addr, l_wdata;
    logic        l_write;

    initial begin
        dn_ready  = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (dn_valid === 1'b1) begin
                logic [31:0] s_addr, s_wdata;
                logic [1:0]  s_kind, s_size;
                logic        s_write;
                s_addr = dn_addr; s_wdata = dn_wdata; s_kind = dn_kind;
                s_size = dn_size; s_write = dn_write;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                check(dn_valid === 1'b1 && dn_addr == s_addr && dn_wdata == s_wdata &&
                      dn_kind == s_kind && dn_size == s_size && dn_write == s_write,
                      "R9 payload held until ready", dn_addr, s_addr);
                l_addr = dn_addr; l_wdata = dn_wdata; l_kind = dn_kind;
                l_size = dn_size; l_write = dn_write;
                nreq++;
                dn_ready = 1'b1;
                @(negedge clk);
                dn_ready = 1'b0;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                rsp_data  = l_write ? 32'hDEAD_0000 : rsp_fn(l_addr);
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int lat, output int reqs);
        int n0;
        @(negedge clk);
        n0 = nreq;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_size = sz; cpu_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (cpu_ack !== 1'b1 && lat < 1000);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        reqs = nreq - n0;
        if (lat >= 1000) check(1'b0, "R9 access never acknowledged", 32'(lat), 32'd0);
    endtask

    // Bench model of local state
    logic [31:0] cfg_m [64];
    logic [31:0] caddr_m, mb_m, ib_m;

    task automatic reg_wr(input int al, input logic [9:0] off, input logic [31:0] d);
        logic [31:0] rd; int lat, rq;
        access(1'b1, reg_base(al) + 32'(off), 2'd2, d, rd, lat, rq);
        check(lat == 1 && rq == 0, "R10 local write acknowledged next edge", 32'(lat), 32'd1);
        if (off < 10'h100)       cfg_m[off[7:2]] = d;
        else if (off == 10'h1C0) caddr_m = d;
        else if (off == 10'h1C4) mb_m = d;
        else if (off == 10'h1C8) ib_m = d;
    endtask

    task automatic reg_rd(input int al, input logic [9:0] off, input logic [31:0] exp, input string tag);
        logic [31:0] rd; int lat, rq;
        access(1'b0, reg_base(al) + 32'(off), 2'd2, 32'h0, rd, lat, rq);
        check(rd == exp, tag, rd, exp);
        check(lat == 1 && rq == 0, "R10 local read acknowledged next edge", 32'(lat), 32'd1);
    endtask

    task automatic down(input bit we, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [1:0] ekind,
                        input logic [31:0] eaddr, input logic [1:0] esz, input string tag);
        logic [31:0] rd; int lat, rq;
        access(we, addr, sz, wd, rd, lat, rq);
        check(rq == 1, {tag, " one request"}, 32'(rq), 32'd1);
        check(l_kind == ekind && l_size == esz && l_write == we, {tag, " kind/size/write"},
              {26'h0, l_kind, l_size, l_write, 1'b0}, {26'h0, ekind, esz, we, 1'b0});
        check(l_addr == eaddr, {tag, " address"}, l_addr, eaddr);
        if (we) check(l_wdata == wd, {tag, " write data"}, l_wdata, wd);
        else    check(rd == rsp_fn(eaddr), {tag, " read data"}, rd, rsp_fn(eaddr));
    endtask

    task automatic miss(input bit we, input logic [31:0] addr, input logic [1:0] sz, input string tag);
        logic [31:0] rd; int lat, rq;
        access(we, addr, sz, 32'hFFFF_FFFF, rd, lat, rq);
        check(rq == 0 && lat == 1, {tag, " no request, next-edge ack"}, 32'(rq), 32'd0);
        check(rd == 32'h0, {tag, " reads zero"}, rd, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_size = '0; cpu_wdata = '0;
        for (int i = 0; i < 64; i++) cfg_m[i] = 32'h0;
        cfg_m[0] = {16'h350E, VEND};
        cfg_m[1] = 32'h0290_0080;
        caddr_m = '0; mb_m = '0; ib_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cpu_ack == 1'b0 && dn_valid == 1'b0, "R1 outputs idle in reset", {31'h0, cpu_ack}, 32'h0);
        rst_n = 1'b1;

        // R1: reset contents
        reg_rd(0, 10'h000, {16'h350E, VEND}, "R1 word0 ids");
        reg_rd(1, 10'h004, 32'h0290_0080, "R1 word1 status/command");
        reg_rd(0, 10'h014, 32'h0, "R1 other word zero");
        reg_rd(0, 10'h1C0, 32'h0, "R1 config address zero");

        // R2 / R7: write via one alias, read via the other
        reg_wr(0, 10'h00C, 32'hCAFE_1234);
        reg_rd(1, 10'h00C, 32'hCAFE_1234, "R2 R7 config word across aliases");
        reg_wr(1, 10'h0FC, 32'h0BAD_F00D);
        reg_rd(0, 10'h0FC, 32'h0BAD_F00D, "R2 last config word");

        // R3: unmapped writes ignored, base registers read zero
        reg_wr(0, 10'h100, 32'h1111_2222);
        reg_rd(0, 10'h100, 32'h0, "R3 unmapped offset reads zero");
        reg_wr(0, 10'h1CC, 32'h3333_4444);
        reg_rd(0, 10'h1C0, 32'h0, "R3 unmapped write left address register");
        reg_rd(0, 10'h000, {16'h350E, VEND}, "R3 unmapped write left config");

        // R4: back-to-back address write then data port
        reg_wr(0, 10'h1C0, 32'h8000_0810);
        reg_rd(1, 10'h1C0, 32'h8000_0810, "R3 address register readback");
        down(1'b1, 32'hFE20_0220, 2'd2, 32'h1357_9BDF, 2'd0, 32'h8000_0810, 2'd2, "R4 data port write");
        down(1'b0, 32'h1E20_0220, 2'd2, 32'h0, 2'd0, 32'h8000_0810, 2'd2, "R4 data port read");

        // R5: memory base with wrap, both aliases
        reg_wr(1, 10'h1C4, 32'hFFFF_FFF0);
        reg_rd(0, 10'h1C4, 32'h0, "R3 memory base reads zero");
        down(1'b0, 32'h1D00_0020, 2'd1, 32'h0, 2'd1, 32'h0000_0010, 2'd1, "R5 memory wrap");
        down(1'b1, 32'hFD12_3456, 2'd0, 32'h0000_00A5, 2'd1, 32'h0012_3446, 2'd0, "R5 R7 memory alias byte");

        // R6: I/O base
        reg_wr(0, 10'h1C8, 32'h0000_1000);
        reg_rd(1, 10'h1C8, 32'h0, "R3 I/O base reads zero");
        down(1'b0, 32'h1E27_FFFC, 2'd2, 32'h0, 2'd2, 32'h0004_0FFC, 2'd2, "R6 I/O last word");
        down(1'b1, 32'hFE24_0002, 2'd1, 32'h0000_BEEF, 2'd2, 32'h0000_1002, 2'd1, "R6 R7 I/O alias half");
        reg_wr(0, 10'h1C8, 32'hFFFF_FF00);
        down(1'b0, 32'h1E24_0180, 2'd0, 32'h0, 2'd2, 32'h0000_0080, 2'd0, "R6 I/O wrap");

        // R8: misses
        miss(1'b0, 32'h1E20_0224, 2'd2, "R8 past control window");
        miss(1'b0, 32'h1E20_0000, 2'd1, "R8 halfword control read");
        miss(1'b1, 32'h1E20_0008, 2'd0, "R8 byte control write");
        reg_rd(0, 10'h008, cfg_m[2], "R8 byte control write ignored");
        miss(1'b0, 32'h1D00_0000, 2'd3, "R8 size code 3");
        miss(1'b0, 32'h1E28_0000, 2'd2, "R8 past I/O window");
        miss(1'b1, 32'h1CFF_FFFC, 2'd2, "R8 below memory window");

        // Random mix
        for (int it = 0; it < 250; it++) begin
            int          op, al;
            logic [31:0] r;
            logic [9:0]  wo;
            op = int'($urandom_range(0, 7));
            al = int'($urandom_range(0, 1));
            r  = $urandom;
            wo = {2'b00, r[5:0], 2'b00};
            unique case (op)
                0: reg_wr(al, wo, $urandom);
                1: reg_rd(al, wo, cfg_m[wo[7:2]], "R2 random config read");
                2: begin
                    logic [9:0] bo;
                    bo = (r[9:8] == 2'd0) ? 10'h1C0 : (r[9:8] == 2'd1) ? 10'h1C4 : 10'h1C8;
                    reg_wr(al, bo, $urandom);
                    reg_rd(al ^ 1, 10'h1C0, caddr_m, "R3 random address readback");
                end
                3: down(r[31], reg_base(al) + 32'h220, 2'd2, $urandom, 2'd0, caddr_m, 2'd2, "R4 random data port");
                4: begin
                    logic [1:0] sz;
                    sz = 2'(r[25:24] % 3);
                    down(r[31], mem_base_a(al) + {8'h0, r[23:0]}, sz, $urandom, 2'd1,
                         {8'h0, r[23:0]} + mb_m, sz, "R5 random memory");
                end
                5: begin
                    logic [1:0] sz;
                    sz = 2'(r[25:24] % 3);
                    down(r[31], io_base_a(al) + {14'h0, r[17:0]}, sz, $urandom, 2'd2,
                         {14'h0, r[17:0]} + ib_m, sz, "R6 random I/O");
                end
                6: miss(r[31], {4'h4, r[27:0]}, 2'(r[29:28] % 3), "R8 random unmapped");
                default: miss(1'b0, reg_base(al) + 32'(wo), r[1] ? 2'd0 : 2'd1, "R8 random narrow control");
            endcase
        end

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule